// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write single 16-bit words in an external asynchronous static RAM. The host sees a request/ready handshake. It presents an address, write data, a read/write flag and a two-bit byte mask, and it gets back a one-cycle response pulse with read data. On the RAM side the block drives the address, chip enable, output enable, write enable and two byte-lane enables. It also drives a data bus that is split into an input, an output and an output-enable, which a pad ring turns into a tristate bus.

Every timing figure of the RAM is a parameter in nanoseconds. Each one is rounded up to a whole number of clock cycles from `CLK_PERIOD_NS`, and every phase lasts at least one cycle. Writes hold chip enable, write enable and the byte enables low over the same interval, and output enable stays low throughout. Each write therefore begins with a turnaround phase in which the controller does not drive the bus. Reads hold the enables low until the slowest data-valid path has elapsed, and the data is captured on the edge that ends the read.

After reset the block waits out a power-up interval with every enable inactive before it accepts the first request.

Top module: `sram_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly N_PWR = ceil(T_PWR_NS / CLK_PERIOD_NS) cycles (12500 with defaults). During that time every RAM enable is high and the data bus is not driven.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low whenever chip enable is low. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R3: A read holds chip enable, output enable and the selected byte enables low, with write enable high, for N_RD cycles. N_RD is the largest rounded value of read cycle time, address access, chip-enable access, output-enable access and byte-enable access, which is 2 with defaults. `rsp_valid` is seen N_RD+1 cycles after the accepting edge, and `rsp_rdata` carries the stored word.
- R4: Mask bit 1 selects the upper lane (data bits 15:8, `sram_ub_n`) and mask bit 0 selects the lower lane (bits 7:0, `sram_lb_n`). A read returns zero in every lane whose mask bit is clear.
- R5: A write pulls chip enable, write enable and the selected byte enables low in the same cycle and releases them together. Output enable stays low throughout. The low interval lasts N_TA+N_DS cycles (2 with defaults), and only the selected lanes of the word are changed.
- R6: The data bus is not driven during the first N_TA = ceil(write-enable-low-to-high-Z) cycles of a write. It is then driven for N_DS cycles up to the end of the write, with a value that does not change. N_DS is at least the setup time, and it stretches the write to meet the pulse-width, address-valid and cycle-time minimums.
- R7: In the cycle after a write ends, the data bus is still driven with the same value while all enables are high. After that cycle the bus is released.
- R8: The data bus is never driven while the RAM could be driving it (chip enable low, output enable low, write enable high). At least one cycle with all enables high separates the end of any access from the start of a write.
- R9: A request with mask 00 produces `rsp_valid` in the next cycle, keeps `req_ready` high and toggles no RAM enable, so memory contents are unchanged.
- R10: `sram_addr` holds its value for every cycle in which chip enable stays low and through the cycle in which it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | RAM address bus |
| sram_dq_i | input | 16 | Data from the RAM pins |
| sram_dq_o | output | 16 | Data to the RAM pins |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |

## Verification
A sequencer stuck in or skipping a phase shows up within one access. The low interval of chip enable or write enable comes out at the wrong length, or the bus driver turns on in the first write cycle and collides with the RAM's outputs in the cycle-accurate pin monitor. A wrong lane register corrupts the word that the bench's RAM model stores at the end of the write. That corruption appears at `rsp_rdata` on the next read of the address and is compared against the scoreboard. A faulty power-up counter moves the first rise of `req_ready` away from cycle N_PWR.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_RD,
        ST_WR_TA,
        ST_WR_DAT,
        ST_WR_HOLD,
        ST_GAP
    } ctl_state_e;

    // Registered pin controls; all enables active low
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } pin_ctl_t;

    // Round a nanosecond figure up to clock cycles, never below one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for a state and selected lanes (bit 1 upper, bit 0 lower)
    function automatic pin_ctl_t pins_for(input ctl_state_e st, input logic [1:0] lanes);
        pin_ctl_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_RD, ST_WR_TA, ST_WR_DAT: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.ub_n = ~lanes[1];
                p.lb_n = ~lanes[0];
                p.we_n = (st == ST_RD);
                p.dq_oe = (st == ST_WR_DAT);
            end
            ST_WR_HOLD: p.dq_oe = 1'b1;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
    parameter int N_CYC = 12500
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int LIMIT = N_CYC - 1;
    localparam int W     = (N_CYC > 1) ? $clog2(N_CYC) : 1;

    logic [W-1:0] cnt;

    assign done = (cnt == W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_PWR_NS      = 100000,
    parameter int T_RC_NS       = 10,
    parameter int T_AA_NS       = 10,
    parameter int T_ACE_NS      = 10,
    parameter int T_DOE_NS      = 5,
    parameter int T_DBE_NS      = 5,
    parameter int T_WC_NS       = 10,
    parameter int T_PWE_NS      = 7,
    parameter int T_SCE_NS      = 7,
    parameter int T_BW_NS       = 7,
    parameter int T_AW_NS       = 7,
    parameter int T_SD_NS       = 5,
    parameter int T_HZWE_NS     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [15:0]       sram_dq_i,
    output logic [15:0]       sram_dq_o,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n
);
    localparam int CP    = CLK_PERIOD_NS;
    localparam int N_PWR = ns_to_cyc(T_PWR_NS, CP);
    localparam int N_RD  = imax(imax(ns_to_cyc(T_RC_NS, CP), ns_to_cyc(T_AA_NS, CP)),
                                imax(ns_to_cyc(T_ACE_NS, CP),
                                     imax(ns_to_cyc(T_DOE_NS, CP), ns_to_cyc(T_DBE_NS, CP))));
    localparam int N_TA  = ns_to_cyc(T_HZWE_NS, CP);
    localparam int N_DS  = imax(imax(ns_to_cyc(T_SD_NS, CP), ns_to_cyc(T_PWE_NS, CP) - N_TA),
                                imax(imax(ns_to_cyc(T_SCE_NS, CP), ns_to_cyc(T_BW_NS, CP)) - N_TA,
                                     imax(ns_to_cyc(T_AW_NS, CP), ns_to_cyc(T_WC_NS, CP)) - N_TA));
    localparam int T_MAX = imax(N_RD, imax(N_TA, N_DS));
    localparam int T_W   = $clog2(T_MAX + 1);

    ctl_state_e        state_q, state_d;
    pin_ctl_t          pins_q;
    logic [1:0]        lanes_q, lanes_d;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic              pwr_done, tmr_exp, tmr_load, accept, zero_req;
    logic [T_W-1:0]    tmr_val;

    sram_pwrup_wait #(.N_CYC(N_PWR)) u_pwr (
        .clk(clk), .rst(rst), .done(pwr_done)
    );

    sram_phase_timer #(.W(T_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign zero_req  = accept && (req_mask == 2'b00);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        lanes_d  = lanes_q;
        case (state_q)
            ST_PWRUP:   if (pwr_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (accept && !zero_req) begin
                    lanes_d  = req_mask;
                    tmr_load = 1'b1;
                    if (req_we) begin
                        state_d = ST_WR_TA;
                        tmr_val = T_W'(N_TA - 1);
                    end else begin
                        state_d = ST_RD;
                        tmr_val = T_W'(N_RD - 1);
                    end
                end
            end
            ST_RD:      if (tmr_exp) state_d = ST_GAP;
            ST_WR_TA: begin
                if (tmr_exp) begin
                    state_d  = ST_WR_DAT;
                    tmr_load = 1'b1;
                    tmr_val  = T_W'(N_DS - 1);
                end
            end
            ST_WR_DAT:  if (tmr_exp) state_d = ST_WR_HOLD;
            ST_WR_HOLD: state_d = ST_IDLE;
            ST_GAP:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_PWRUP;
            pins_q    <= pins_for(ST_PWRUP, 2'b00);
            lanes_q   <= 2'b00;
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state_q   <= state_d;
            pins_q    <= pins_for(state_d, lanes_d);
            lanes_q   <= lanes_d;
            rsp_valid <= zero_req
                       || ((state_q == ST_RD) && tmr_exp)
                       || ((state_q == ST_WR_DAT) && tmr_exp);
            if (accept && !zero_req) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if ((state_q == ST_RD) && tmr_exp)
                rsp_rdata <= {lanes_q[1] ? sram_dq_i[15:8] : 8'h00,
                              lanes_q[0] ? sram_dq_i[7:0]  : 8'h00};
        end
    end

    assign sram_addr  = addr_q;
    assign sram_dq_o  = wdata_q;
    assign sram_dq_oe = pins_q.dq_oe;
    assign sram_ce_n  = pins_q.ce_n;
    assign sram_oe_n  = pins_q.oe_n;
    assign sram_we_n  = pins_q.we_n;
    assign sram_ub_n  = pins_q.ub_n;
    assign sram_lb_n  = pins_q.lb_n;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst,
    input ctl_state_e    st,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_mask,
    input logic          rsp_valid,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          ub_n,
    input logic          lb_n,
    input logic          dq_oe,
    input logic [15:0]   dq_o,
    input logic [AW-1:0] addr
);
    // R1
    pwrup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PWRUP) |-> (ce_n && oe_n && we_n && ub_n && lb_n && !dq_oe && !req_ready));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> !req_ready);

    // R5
    write_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && !oe_n && (!ub_n || !lb_n)));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !we_n) |-> $past(!we_n));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (dq_oe && $stable(dq_o)));

    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (ce_n || oe_n || !we_n));

    // R9
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_mask == 2'b00)) |=> (ce_n && rsp_valid && req_ready));

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .st(state_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_mask(req_mask),
    .rsp_valid(rsp_valid),
    .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .ub_n(sram_ub_n), .lb_n(sram_lb_n),
    .dq_oe(sram_dq_oe), .dq_o(sram_dq_o), .addr(sram_addr)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    localparam int AW = 18;
    localparam int CP = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CP - 1) / CP;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_PWR = cyc(100000);
    localparam int B_RD  = mx(mx(cyc(10), cyc(10)), mx(cyc(10), mx(cyc(5), cyc(5))));
    localparam int B_TA  = cyc(5);
    localparam int B_DS  = mx(mx(cyc(5), cyc(7) - B_TA), mx(cyc(7) - B_TA, cyc(10) - B_TA));

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = 2'b00;
    logic          req_ready, rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic [15:0]   sram_dq_i, sram_dq_o;
    logic          sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;

    sram_ctrl #(.ADDR_W(AW), .CLK_PERIOD_NS(CP)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_dq_i(sram_dq_i), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural RAM model
    logic [15:0] ram [int];
    logic [15:0] ref_mem [int];

    always_comb begin
        logic [15:0] w;
        sram_dq_i = 16'hBEEF;
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            w = ram.exists(int'(sram_addr)) ? ram[int'(sram_addr)] : 16'h0000;
            sram_dq_i = {sram_ub_n ? 8'h5A : w[15:8], sram_lb_n ? 8'hC3 : w[7:0]};
        end
    end

    // Pin monitor, sampled at the falling edge
    bit            pwr_phase = 1'b1;
    logic          p_ce = 1, p_oe = 1, p_we = 1, p_ub = 1, p_lb = 1, p_dqoe = 0;
    logic [15:0]   p_dq = '0;
    logic [AW-1:0] p_addr = '0;
    int            ce_run = 0, ds_run = 0, ce_falls = 0;
    bit            acc_wr = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pwr_phase) begin
                if (req_ready) pwr_phase = 0;
                else chk(sram_ce_n && sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n && !sram_dq_oe,
                         "R1 enables idle during power-up", {26'd0, sram_ce_n, sram_oe_n, sram_we_n,
                         sram_ub_n, sram_lb_n, sram_dq_oe}, 32'h3E);
            end
            if (sram_dq_oe)
                chk(sram_ce_n || sram_oe_n || !sram_we_n, "R8 bus contention", 0, 1);
            if (!sram_we_n) begin
                acc_wr = 1;
                chk(!sram_ce_n && !sram_oe_n && (!sram_ub_n || !sram_lb_n), "R5 write overlap", 0, 1);
                if (p_we) chk(p_ce && p_oe, "R8 idle cycle before write", {p_ce, p_oe}, 2'b11);
            end
            if (!sram_ce_n && !sram_ub_n)
                chk(!req_ready, "R2 ready low while busy", req_ready, 0);
            if (sram_dq_oe && !sram_we_n) begin
                ds_run++;
                chk(!p_we, "R6 turnaround before drive", p_we, 0);
                if (p_dqoe) chk(sram_dq_o == p_dq, "R6 data stable", sram_dq_o, p_dq);
            end
            if (!sram_ce_n) begin
                if (p_ce) ce_falls++;
                else chk(sram_addr == p_addr, "R10 address stable", sram_addr, p_addr);
                ce_run++;
            end
            if (sram_ce_n && !p_ce) begin
                chk(sram_addr == p_addr, "R10 address held at end", sram_addr, p_addr);
                if (acc_wr) begin
                    logic [15:0] w;
                    chk(ce_run == B_TA + B_DS, "R5 write length", ce_run, B_TA + B_DS);
                    chk(ds_run == B_DS, "R6 data drive length", ds_run, B_DS);
                    chk(sram_dq_oe && sram_dq_o == p_dq, "R7 data hold", sram_dq_o, p_dq);
                    chk(p_dqoe, "R6 data set up at write end", p_dqoe, 1);
                    w = ram.exists(int'(p_addr)) ? ram[int'(p_addr)] : 16'h0000;
                    if (!p_ub) w[15:8] = p_dq[15:8];
                    if (!p_lb) w[7:0]  = p_dq[7:0];
                    ram[int'(p_addr)] = w;
                end else begin
                    chk(ce_run == B_RD, "R3 read length", ce_run, B_RD);
                end
                ce_run = 0; ds_run = 0; acc_wr = 0;
            end
            if (p_dqoe && sram_we_n && p_we && !sram_dq_oe) ; // bus released after hold
        end
        p_ce = sram_ce_n; p_oe = sram_oe_n; p_we = sram_we_n; p_ub = sram_ub_n;
        p_lb = sram_lb_n; p_dqoe = sram_dq_oe; p_dq = sram_dq_o; p_addr = sram_addr;
    end

    task automatic do_req(input bit we, input int a, input logic [15:0] d, input logic [1:0] m,
                          input string tag);
        int lat, exp_lat;
        logic [15:0] cur, expd;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (m == 2'b00) ? 1 : (we ? B_TA + B_DS + 1 : B_RD + 1);
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        cur = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
        if (we) begin
            if (m[1]) cur[15:8] = d[15:8];
            if (m[0]) cur[7:0]  = d[7:0];
            ref_mem[a] = cur;
        end else if (m != 2'b00) begin
            expd = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
            chk(rsp_rdata == expd, {tag, " read data"}, rsp_rdata, expd);
        end
        @(negedge clk);
        chk(!rsp_valid, "R2 single response pulse", rsp_valid, 0);
    endtask

    initial begin
        int pw, falls0;
        repeat (4) @(negedge clk);
        chk(!req_ready && sram_ce_n && sram_we_n && !sram_dq_oe && !rsp_valid,
            "R1 reset state", {req_ready, sram_ce_n, sram_we_n, sram_dq_oe}, 4'b0110);
        rst = 0;
        pw = 0;
        while (!req_ready) begin
            @(negedge clk);
            pw++;
        end
        chk(pw == B_PWR, "R1 power-up wait", pw, B_PWR);

        do_req(1, 0,         16'h1234, 2'b11, "R5 write full");
        do_req(1, 2**AW - 1, 16'hABCD, 2'b11, "R5 write top address");
        do_req(1, 5,         16'h0F0F, 2'b11, "R5 write");
        do_req(0, 0,         16'h0000, 2'b11, "R3 read");
        do_req(0, 2**AW - 1, 16'h0000, 2'b11, "R3 read top address");
        do_req(0, 5,         16'h0000, 2'b11, "R3 read");
        do_req(1, 5,         16'h1177, 2'b01, "R5 lower lane write");
        do_req(1, 5,         16'h9922, 2'b10, "R5 upper lane write");
        do_req(0, 5,         16'h0000, 2'b11, "R5 merged lanes");
        do_req(0, 2**AW - 1, 16'h0000, 2'b10, "R4 upper-only read");
        do_req(0, 2**AW - 1, 16'h0000, 2'b01, "R4 lower-only read");

        falls0 = ce_falls;
        do_req(1, 0, 16'hFFFF, 2'b00, "R9 zero-mask write");
        do_req(0, 0, 16'h0000, 2'b00, "R9 zero-mask read");
        chk(ce_falls == falls0, "R9 no enable toggled", ce_falls, falls0);
        chk(req_ready, "R9 ready kept", req_ready, 1);
        do_req(0, 0, 16'h0000, 2'b11, "R9 memory unchanged");

        do_req(0, 7,   16'h0000, 2'b11, "R8 read before write");
        do_req(1, 7,   16'h5AA5, 2'b11, "R8 write after read");
        do_req(0, 7,   16'h0000, 2'b11, "R8 read back");
        do_req(0, 100, 16'h0000, 2'b11, "R3 unwritten address");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule